// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block produces the instruction fetch address of a small processor core. It holds a 13-bit program counter that covers 8K instruction words, split into four 2K-word pages. In each cycle an operation code from the decoder selects one of these actions:
- advance to the next word;
- jump or call inside a page given by an 11-bit target;
- return through a circular eight-entry hardware stack;
- overwrite the low address byte.

Whenever the counter needs a page, it takes the page bits from an external page-latch byte, never from the instruction.

An accepted interrupt has priority over the decoded operation. It saves the current address on the stack and forces the fixed interrupt vector. Every operation that redirects fetch (jump, call, the three returns and interrupt entry) costs one extra cycle. In that cycle the block raises a flush flag, holds the counter, and ignores its inputs. A one-cycle pulse tells the interrupt controller to re-enable interrupts after a return-from-interrupt.

Top module: `pc_sequencer`

## Requirements
- R1: Asynchronous active-low reset sets the PC to 0x0000, clears the flush flag and the enable pulse, and empties the stack.
- R2: Operation code 1 (sequential) advances the PC by one modulo 8K, so 0x1FFF is followed by 0x0000.
- R3: Operation code 2 (jump) loads PC[10:0] from the 11-bit target and PC[12:11] from page-latch bits 4:3. The other latch bits have no effect.
- R4: Operation code 3 (call) saves PC+1 (modulo 8K) on the stack and then loads the PC as in R3.
- R5: Operation codes 4 (return) and 5 (return with literal) load the PC from the most recent stack entry and remove it, in last-in first-out order.
- R6: Operation code 6 (return from interrupt) behaves as R5 and also drives the enable pulse high for exactly the following cycle.
- R7: An accepted interrupt takes priority over the operation code, saves the current PC on the stack and loads 0x0004.
- R8: Operation code 7 (low-byte write) loads PC[7:0] from the data byte and PC[12:8] from page-latch bits 4:0. Latch bits 7:5 have no effect.
- R9: Each jump, call, return or interrupt entry is followed by one flush cycle. In that cycle the flush flag is high, the PC holds, and both the operation code and the interrupt input are ignored.
- R10: The stack has eight entries and no error indication. A ninth push overwrites the oldest entry. A pop beyond the remaining entries returns whatever the wrapped slot still holds.
- R11: Operation code 0 (hold) leaves the PC unchanged and takes one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code for this cycle |
| irq_take_i | input | 1 | Interrupt accepted this cycle |
| target_i | input | 11 | In-page target for jump and call |
| data_i | input | 8 | New low PC byte for low-byte write |
| page_latch_i | input | 8 | Page-latch byte supplying upper PC bits |
| pc_o | output | 13 | Current program counter |
| flush_o | output | 1 | High during the second cycle of a redirect |
| gie_set_o | output | 1 | One-cycle pulse after return from interrupt |

## Verification
The vector table steps the counter through runs of sequential advances, including the wrap at the top of memory. It then mixes page jumps under latch bytes whose unused bits are set, low-byte writes to the highest and lowest pages, and a call followed by an interrupt that arrives together with another call. The pattern of return addresses shows whether the interrupt displaced the call or both were saved, and the ordering of the two return kinds shows whether the stack is last-in first-out. Every redirect is followed by an operation the flush cycle must ignore, which separates a correct one-cycle bubble from one that lets the input through. A directed run of nine calls and nine returns alternating both return codes shows that the oldest entry is overwritten and that the ninth pop yields the wrapped slot.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_SEQ   = 3'd1,
    OP_JUMP  = 3'd2,
    OP_CALL  = 3'd3,
    OP_RET   = 3'd4,
    OP_RETLW = 3'd5,
    OP_RETI  = 3'd6,
    OP_PCLW  = 3'd7
  } pc_op_e;
endpackage

// File: rtl/pcs_retstack.sv
module pcs_retstack #(
  parameter int DEPTH = 8,
  parameter int W     = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_val,
  output logic [W-1:0] tos
);
  localparam int SP_W = $clog2(DEPTH);

  logic [W-1:0]    mem [DEPTH];
  logic [SP_W-1:0] sp;
  logic [SP_W-1:0] sp_top;

  // slot most recently written; wraps below zero to the last slot
  assign sp_top = sp - 1'b1;
  assign tos    = mem[sp_top];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push) begin
      mem[sp] <= push_val;
      sp      <= sp + 1'b1;
    end else if (pop) begin
      sp <= sp_top;
    end
  end

  // R10: pointer wraps silently on push
  a_r10_push_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> sp == SP_W'($past(sp) + 1'b1));
  // R5: pop exposes the previous slot
  a_r5_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> sp == SP_W'($past(sp) - 1'b1));
  // R10: decoder never requests both at once
  a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
endmodule

// File: rtl/pcs_next.sv
module pcs_next
  import pcs_pkg::*;
#(
  parameter int              PC_W    = 13,
  parameter int              TGT_W   = 11,
  parameter logic [PC_W-1:0] VEC_IRQ = 13'h0004
) (
  input  pc_op_e            op,
  input  logic              irq,
  input  logic              flush,
  input  logic [PC_W-1:0]   pc,
  input  logic [PC_W-1:0]   tos,
  input  logic [TGT_W-1:0]  tgt,
  input  logic [7:0]        data,
  input  logic [7:0]        latch,
  output logic [PC_W-1:0]   pc_nxt,
  output logic              push,
  output logic [PC_W-1:0]   push_val,
  output logic              pop,
  output logic              branch,
  output logic              ev_irq,
  output logic              ev_reti
);
  localparam int HI_MSB = PC_W - 9;
  localparam int PG_LSB = TGT_W - 8;

  function automatic logic [PC_W-1:0] f_inc(input logic [PC_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [PC_W-1:0] f_page_join(input logic [7:0] l,
                                                   input logic [TGT_W-1:0] t);
    return {l[HI_MSB:PG_LSB], t};
  endfunction

  function automatic logic [PC_W-1:0] f_low_join(input logic [7:0] l,
                                                  input logic [7:0] d);
    return {l[HI_MSB:0], d};
  endfunction

  logic unused_latch;
  assign unused_latch = &{1'b0, latch[7:HI_MSB+1]};

  always_comb begin
    pc_nxt   = pc;
    push     = 1'b0;
    push_val = f_inc(pc);
    pop      = 1'b0;
    branch   = 1'b0;
    ev_irq   = 1'b0;
    ev_reti  = 1'b0;
    if (!flush) begin
      if (irq) begin
        push     = 1'b1;
        push_val = pc;
        pc_nxt   = VEC_IRQ;
        branch   = 1'b1;
        ev_irq   = 1'b1;
      end else begin
        case (op)
          OP_HOLD: pc_nxt = pc;
          OP_SEQ:  pc_nxt = f_inc(pc);
          OP_JUMP: begin
            pc_nxt = f_page_join(latch, tgt);
            branch = 1'b1;
          end
          OP_CALL: begin
            push   = 1'b1;
            pc_nxt = f_page_join(latch, tgt);
            branch = 1'b1;
          end
          OP_RET, OP_RETLW: begin
            pop    = 1'b1;
            pc_nxt = tos;
            branch = 1'b1;
          end
          OP_RETI: begin
            pop     = 1'b1;
            pc_nxt  = tos;
            branch  = 1'b1;
            ev_reti = 1'b1;
          end
          OP_PCLW: pc_nxt = f_low_join(latch, data);
          default: pc_nxt = pc;
        endcase
      end
    end
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcs_pkg::*;
#(
  parameter int              PC_W    = 13,
  parameter int              TGT_W   = 11,
  parameter int              DEPTH   = 8,
  parameter logic [PC_W-1:0] VEC_RST = 13'h0000,
  parameter logic [PC_W-1:0] VEC_IRQ = 13'h0004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic              irq_take_i,
  input  logic [TGT_W-1:0]  target_i,
  input  logic [7:0]        data_i,
  input  logic [7:0]        page_latch_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              flush_o,
  output logic              gie_set_o
);
  logic [PC_W-1:0] pc_q, pc_nxt, tos, push_val;
  logic            flush_q, gie_q;
  logic            push, pop, branch, ev_irq, ev_reti;
  pc_op_e          op;

  assign op = pc_op_e'(op_i);

  pcs_next #(.PC_W(PC_W), .TGT_W(TGT_W), .VEC_IRQ(VEC_IRQ)) u_next (
    .op(op), .irq(irq_take_i), .flush(flush_q), .pc(pc_q), .tos(tos),
    .tgt(target_i), .data(data_i), .latch(page_latch_i),
    .pc_nxt(pc_nxt), .push(push), .push_val(push_val), .pop(pop),
    .branch(branch), .ev_irq(ev_irq), .ev_reti(ev_reti)
  );

  pcs_retstack #(.DEPTH(DEPTH), .W(PC_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .push_val(push_val), .tos(tos)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= VEC_RST;
      flush_q <= 1'b0;
      gie_q   <= 1'b0;
    end else begin
      pc_q    <= pc_nxt;
      flush_q <= branch;
      gie_q   <= ev_reti;
    end
  end

  assign pc_o      = pc_q;
  assign flush_o   = flush_q;
  assign gie_set_o = gie_q;

  // R9: every redirect is followed by a flush cycle
  a_r9_flush_follows: assert property (@(posedge clk) disable iff (!rst_n)
    branch |=> flush_q);
  // R9: flush holds the PC and lasts a single cycle
  a_r9_flush_hold: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |=> (pc_q == $past(pc_q) && !flush_q));
  // R7: interrupt entry lands on the vector
  a_r7_irq_vector: assert property (@(posedge clk) disable iff (!rst_n)
    ev_irq |=> pc_q == VEC_IRQ);
  // R6: enable pulse follows return from interrupt for one cycle
  a_r6_gie_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reti |=> (gie_q ##1 !gie_q));
  // R2: sequential advance wraps modulo the address space
  a_r2_seq_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd1 && !irq_take_i && !flush_q) |=> pc_q == PC_W'($past(pc_q) + 1'b1));
  // R11: hold keeps the PC
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd0 && !irq_take_i) |=> $stable(pc_q));
endmodule

// File: tb/tb_pc_sequencer.sv
`timescale 1ns/1ps
module tb_pc_sequencer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op;
  logic        irq;
  logic [10:0] tgt;
  logic [7:0]  data;
  logic [7:0]  latch;
  logic [12:0] pc;
  logic        fl, gie;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pc_sequencer dut (
    .clk(clk), .rst_n(rst_n), .op_i(op), .irq_take_i(irq), .target_i(tgt),
    .data_i(data), .page_latch_i(latch), .pc_o(pc), .flush_o(fl), .gie_set_o(gie)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  op;
    logic        irq;
    logic [10:0] tgt;
    logic [7:0]  data;
    logic [7:0]  latch;
    logic [12:0] pc;
    logic        fl;
    logic        gie;
  } vec_t;

  localparam int N = 20;
  localparam vec_t VEC [0:N-1] = '{
    '{4'd2,  3'd1, 1'b0, 11'h000, 8'h00, 8'h00, 13'h0001, 1'b0, 1'b0}, // R2
    '{4'd2,  3'd1, 1'b0, 11'h000, 8'h00, 8'h00, 13'h0002, 1'b0, 1'b0}, // R2
    '{4'd11, 3'd0, 1'b0, 11'h000, 8'h00, 8'h00, 13'h0002, 1'b0, 1'b0}, // R11
    '{4'd3,  3'd2, 1'b0, 11'h155, 8'h00, 8'hFF, 13'h1955, 1'b1, 1'b0}, // R3
    '{4'd9,  3'd1, 1'b1, 11'h7FF, 8'h00, 8'hFF, 13'h1955, 1'b0, 1'b0}, // R9
    '{4'd8,  3'd7, 1'b0, 11'h000, 8'hFF, 8'h1F, 13'h1FFF, 1'b0, 1'b0}, // R8
    '{4'd2,  3'd1, 1'b0, 11'h000, 8'h00, 8'h00, 13'h0000, 1'b0, 1'b0}, // R2 wrap
    '{4'd4,  3'd3, 1'b0, 11'h010, 8'h00, 8'h08, 13'h0810, 1'b1, 1'b0}, // R4
    '{4'd9,  3'd0, 1'b0, 11'h000, 8'h00, 8'h00, 13'h0810, 1'b0, 1'b0}, // R9
    '{4'd2,  3'd1, 1'b0, 11'h000, 8'h00, 8'h00, 13'h0811, 1'b0, 1'b0}, // R2
    '{4'd7,  3'd3, 1'b1, 11'h123, 8'h00, 8'h18, 13'h0004, 1'b1, 1'b0}, // R7
    '{4'd9,  3'd2, 1'b0, 11'h7FF, 8'h00, 8'hFF, 13'h0004, 1'b0, 1'b0}, // R9
    '{4'd2,  3'd1, 1'b0, 11'h000, 8'h00, 8'h00, 13'h0005, 1'b0, 1'b0}, // R2
    '{4'd6,  3'd6, 1'b0, 11'h000, 8'h00, 8'h00, 13'h0811, 1'b1, 1'b1}, // R6
    '{4'd9,  3'd1, 1'b0, 11'h000, 8'h00, 8'h00, 13'h0811, 1'b0, 1'b0}, // R9
    '{4'd5,  3'd4, 1'b0, 11'h000, 8'h00, 8'h00, 13'h0001, 1'b1, 1'b0}, // R5
    '{4'd9,  3'd0, 1'b0, 11'h000, 8'h00, 8'h00, 13'h0001, 1'b0, 1'b0}, // R9
    '{4'd8,  3'd7, 1'b0, 11'h000, 8'h34, 8'hE2, 13'h0234, 1'b0, 1'b0}, // R8
    '{4'd3,  3'd2, 1'b0, 11'h3FF, 8'h00, 8'hE7, 13'h03FF, 1'b1, 1'b0}, // R3
    '{4'd9,  3'd0, 1'b0, 11'h000, 8'h00, 8'h00, 13'h03FF, 1'b0, 1'b0}  // R9
  };

  task automatic drive(input logic [2:0] o, input logic i, input logic [10:0] t,
                       input logic [7:0] d, input logic [7:0] l);
    op = o; irq = i; tgt = t; data = d; latch = l;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [14:0] act, input logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {pc,flush,gie} actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0; op = 3'd0; irq = 1'b0; tgt = '0; data = '0; latch = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", {pc, fl, gie}, {13'h0000, 1'b0, 1'b0});
    rst_n = 1'b1;

    for (int i = 0; i < N; i++) begin
      drive(VEC[i].op, VEC[i].irq, VEC[i].tgt, VEC[i].data, VEC[i].latch);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), {pc, fl, gie},
            {VEC[i].pc, VEC[i].fl, VEC[i].gie});
    end

    // R10: nine calls from addresses 16*k, saving 16*k+1
    for (int k = 0; k < 9; k++) begin
      drive(3'd7, 1'b0, 11'h000, 8'(16 * k), 8'h00);
      drive(3'd3, 1'b0, 11'h100, 8'h00, 8'h00);
      drive(3'd0, 1'b0, 11'h000, 8'h00, 8'h00);
    end
    check("R10 call target", {pc, fl, gie}, {13'h0100, 1'b0, 1'b0});
    // R5/R10: pops alternate return and return-with-literal
    for (int k = 0; k < 9; k++) begin
      int j;
      j = (k == 8) ? 8 : 8 - k;
      drive((k % 2 == 0) ? 3'd4 : 3'd5, 1'b0, 11'h000, 8'h00, 8'h00);
      check($sformatf("R10 pop %0d (R5 order)", k), {pc, fl, gie},
            {13'(16 * j + 1), 1'b1, 1'b0});
      drive(3'd0, 1'b0, 11'h000, 8'h00, 8'h00);
    end

    // R1: reset in the middle of a run
    drive(3'd1, 1'b0, 11'h000, 8'h00, 8'h00);
    drive(3'd2, 1'b0, 11'h0AA, 8'h00, 8'h08);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", {pc, fl, gie}, {13'h0000, 1'b0, 1'b0});
    @(negedge clk);
    rst_n = 1'b1;
    drive(3'd1, 1'b0, 11'h000, 8'h00, 8'h00);
    check("R1 restart R2", {pc, fl, gie}, {13'h0001, 1'b0, 1'b0});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule